// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block drives a raster display. From sixteen-bit-free, plain programmed lengths it produces horizontal sync, vertical sync and data-enable. It also produces the coordinates of the current visible pixel, a one-cycle frame-start pulse and a one-cycle vertical-blank pulse. It advances one pixel per clock. Each line is built from four horizontal regions in a fixed order: sync, back porch, active, front porch. Each frame is built from the same four regions counted in lines. Every region length is programmed as its length minus one, so a stored 0 means one pixel or one line.

A run input starts and stops scanning. While it is low, both counters rest at zero and every timing output stays at its inactive level. Four polarity bits choose, one by one, the active level of hsync, vsync and data-enable, and whether pixel data passes straight through or inverted. The pixel input is a plain bus sampled on every clock. There is no valid/ready handshake: the display consumes one pixel per cycle with no back-pressure, and the pixel source must follow `de`. Timing and polarity settings are latched as a set when scanning starts and again at each frame boundary. A change in mid-frame therefore never tears the current frame.

Top module: `disp_timing_gen`

## Requirements
- R1: Each region lasts its stored value plus one. A line therefore lasts the sum of the four horizontal values plus 4 clocks. A frame lasts that line length times the sum of the four vertical values plus 4.
- R2: Within a line, the order is sync, back porch, active, front porch. hsync is active exactly during the horizontal sync region, which begins on the first cycle of the line.
- R3: The line count advances only on the last cycle of a line. The vertical regions follow the same order as the horizontal ones, and vsync is active for every cycle of the vertical sync lines.
- R4: Internal data-enable is true only when both the horizontal and the vertical region are active. While it is true, `pix_x` and `pix_y` give the offset into the active area, starting at 0. Otherwise both are 0.
- R5: A polarity bit of 1 makes the matching output (hsync, vsync, de) active-high, and 0 makes it active-low. With the data polarity bit at 1, `pix_out` equals `pix_in`, and at 0 it equals the bitwise inverse. Outside data-enable, `pix_out` is 0.
- R6: While `run_en` is low, from the next clock onward, the coordinates are 0, `sof` and `vblank` are low, and hsync, vsync and de sit at their inactive levels. The first cycle after `run_en` rises is cycle 0 of a frame.
- R7: `sof` is high for exactly one cycle per frame, on the first cycle of the frame.
- R8: `vblank` is high for exactly one cycle per frame, on the last cycle of the last active line.
- R9: Timing and polarity inputs changed while scanning take effect only from the first cycle of the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_en | input | 1 | 1 scans, 0 stops and clears the counters |
| h_sync_m1 | input | TW | Horizontal sync width minus one |
| h_back_m1 | input | TW | Horizontal back porch minus one |
| h_act_m1 | input | TW | Visible pixels per line minus one |
| h_front_m1 | input | TW | Horizontal front porch minus one |
| v_sync_m1 | input | TW | Vertical sync lines minus one |
| v_back_m1 | input | TW | Vertical back porch lines minus one |
| v_act_m1 | input | TW | Visible lines minus one |
| v_front_m1 | input | TW | Vertical front porch lines minus one |
| pol_hsync | input | 1 | 1: hsync active-high |
| pol_vsync | input | 1 | 1: vsync active-high |
| pol_de | input | 1 | 1: de active-high |
| pol_data | input | 1 | 1: data as-is, 0: data inverted |
| pix_in | input | DW | Pixel value for the current cycle |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| pix_out | output | DW | Pixel after polarity and blanking |
| pix_x | output | TW | Column in the active area |
| pix_y | output | TW | Row in the active area |
| sof | output | 1 | First cycle of a frame |
| vblank | output | 1 | Last cycle of the last active line |

## Verification
A wrong region count or a wrong transition moves the hsync edges within the same line. It moves the de window and `pix_x` too, so it shows on the first line after a start. A vertical counter that steps at the wrong time shows up as a wrong `pix_y` or a wrong vsync width within one frame. A shadow register that loads at the wrong moment only becomes visible when settings change in mid-frame. The bench therefore makes such a change and compares the remainder of that frame and the next frame, cycle by cycle, against an arithmetic model.

// File: rtl/tg_pkg.sv
package tg_pkg;

  typedef enum logic [1:0] {
    RG_SYNC  = 2'd0,
    RG_BACK  = 2'd1,
    RG_ACT   = 2'd2,
    RG_FRONT = 2'd3
  } region_e;

  function automatic region_e next_rgn(region_e r);
    case (r)
      RG_SYNC:  next_rgn = RG_BACK;
      RG_BACK:  next_rgn = RG_ACT;
      RG_ACT:   next_rgn = RG_FRONT;
      default:  next_rgn = RG_SYNC;
    endcase
  endfunction

endpackage

// File: rtl/tg_axis.sv
module tg_axis
  import tg_pkg::*;
#(
  parameter int unsigned TW = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                step,
  input  logic [3:0][TW-1:0]  len_m1,
  output region_e             rgn,
  output logic [TW-1:0]       cnt,
  output logic                last
);

  logic rgn_end;

  assign rgn_end = (cnt == len_m1[rgn]);
  assign last    = rgn_end && (rgn == RG_FRONT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rgn <= RG_SYNC;
      cnt <= '0;
    end else if (clr) begin
      rgn <= RG_SYNC;
      cnt <= '0;
    end else if (step) begin
      if (rgn_end) begin
        cnt <= '0;
        rgn <= next_rgn(rgn);
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R1: the count inside a region never passes that region's length
  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= len_m1[rgn]);

  // R2: the end of a region moves to the next region at count zero
  p_region_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr && rgn_end) |=> (cnt == '0 && rgn == next_rgn($past(rgn))));

  // R3: without a step the position holds
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !clr) |=> ($stable(cnt) && $stable(rgn)));

endmodule

// File: rtl/tg_shadow.sv
module tg_shadow #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end

  // R9: settings are captured only on a load cycle
  p_shadow_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q));

endmodule

// File: rtl/tg_out.sv
module tg_out #(
  parameter int unsigned DW = 8
) (
  input  logic          run_q,
  input  logic          hs_i,
  input  logic          vs_i,
  input  logic          de_i,
  input  logic [3:0]    pol,
  input  logic [DW-1:0] pix_in,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic [DW-1:0] pix_out
);

  // pol order: [0] hsync, [1] vsync, [2] de, [3] data
  logic hs_a, vs_a, de_a;

  assign hs_a = run_q && hs_i;
  assign vs_a = run_q && vs_i;
  assign de_a = run_q && de_i;

  assign hsync   = pol[0] ? hs_a : !hs_a;
  assign vsync   = pol[1] ? vs_a : !vs_a;
  assign de      = pol[2] ? de_a : !de_a;
  assign pix_out = !de_a ? '0 : (pol[3] ? pix_in : ~pix_in);

  // R5: blanked cycles carry zero data
  always_comb begin
    if (!de_a) p_blank_zero_r5: assert (pix_out == '0);
  end

endmodule

// File: rtl/disp_timing_gen.sv
module disp_timing_gen
  import tg_pkg::*;
#(
  parameter int unsigned TW = 12,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_en,
  input  logic [TW-1:0] h_sync_m1,
  input  logic [TW-1:0] h_back_m1,
  input  logic [TW-1:0] h_act_m1,
  input  logic [TW-1:0] h_front_m1,
  input  logic [TW-1:0] v_sync_m1,
  input  logic [TW-1:0] v_back_m1,
  input  logic [TW-1:0] v_act_m1,
  input  logic [TW-1:0] v_front_m1,
  input  logic          pol_hsync,
  input  logic          pol_vsync,
  input  logic          pol_de,
  input  logic          pol_data,
  input  logic [DW-1:0] pix_in,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic [DW-1:0] pix_out,
  output logic [TW-1:0] pix_x,
  output logic [TW-1:0] pix_y,
  output logic          sof,
  output logic          vblank
);

  localparam int unsigned AXW = 4 * TW;
  localparam int unsigned CW  = 2 * AXW + 4;

  logic                run_q;
  logic [CW-1:0]       cfg_d, cfg_q;
  logic [3:0][TW-1:0]  h_len, v_len;
  logic [3:0]          pol_q;
  region_e             h_rgn, v_rgn;
  logic [TW-1:0]       h_cnt, v_cnt;
  logic                h_last, v_last;
  logic                frame_end, cfg_load;
  logic                hs_i, vs_i, de_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= run_en;
  end

  assign cfg_d = {h_front_m1, h_act_m1, h_back_m1, h_sync_m1,
                  v_front_m1, v_act_m1, v_back_m1, v_sync_m1,
                  pol_data, pol_de, pol_vsync, pol_hsync};

  assign frame_end = run_q && h_last && v_last;
  assign cfg_load  = !run_q || frame_end;

  tg_shadow #(.W(CW)) u_shadow (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (cfg_load),
    .d     (cfg_d),
    .q     (cfg_q)
  );

  assign h_len = cfg_q[CW-1 -: AXW];
  assign v_len = cfg_q[AXW+3 -: AXW];
  assign pol_q = cfg_q[3:0];

  tg_axis #(.TW(TW)) u_hor (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (!run_en),
    .step   (run_q),
    .len_m1 (h_len),
    .rgn    (h_rgn),
    .cnt    (h_cnt),
    .last   (h_last)
  );

  tg_axis #(.TW(TW)) u_ver (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (!run_en),
    .step   (run_q && h_last),
    .len_m1 (v_len),
    .rgn    (v_rgn),
    .cnt    (v_cnt),
    .last   (v_last)
  );

  assign hs_i = (h_rgn == RG_SYNC);
  assign vs_i = (v_rgn == RG_SYNC);
  assign de_i = (h_rgn == RG_ACT) && (v_rgn == RG_ACT);

  tg_out #(.DW(DW)) u_out (
    .run_q   (run_q),
    .hs_i    (hs_i),
    .vs_i    (vs_i),
    .de_i    (de_i),
    .pol     (pol_q),
    .pix_in  (pix_in),
    .hsync   (hsync),
    .vsync   (vsync),
    .de      (de),
    .pix_out (pix_out)
  );

  assign pix_x  = (run_q && de_i) ? h_cnt : '0;
  assign pix_y  = (run_q && de_i) ? v_cnt : '0;
  assign sof    = run_q && hs_i && vs_i && (h_cnt == '0) && (v_cnt == '0);
  assign vblank = run_q && (v_rgn == RG_ACT) && (v_cnt == v_len[RG_ACT]) && h_last;

  // R3: the line count moves only on a line's last cycle
  p_line_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && run_en && !h_last) |=> ($stable(v_cnt) && $stable(v_rgn)));

  // R6: stopping clears the coordinates and the pulses
  p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (pix_x == '0 && pix_y == '0 && !sof && !vblank));

  // R7: frame start lasts one cycle
  p_sof_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sof |=> !sof);

  // R8: vertical blank pulse lasts one cycle
  p_vblank_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    vblank |=> !vblank);

  // R9: a frame boundary while running starts a new frame
  p_frame_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && run_en) |=> sof);

endmodule

// File: tb/tb_disp_timing_gen.sv
module tb_disp_timing_gen;

  localparam int TW = 12;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          run_en = 1'b0;
  logic [TW-1:0] hs_m1, hb_m1, ha_m1, hf_m1, vs_m1, vb_m1, va_m1, vf_m1;
  logic          p_hs, p_vs, p_de, p_dt;
  logic [DW-1:0] pix_in = '0;
  logic          hsync, vsync, de, sof, vblank;
  logic [DW-1:0] pix_out;
  logic [TW-1:0] pix_x, pix_y;

  always #5 clk = ~clk;

  disp_timing_gen #(.TW(TW), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .run_en(run_en),
    .h_sync_m1(hs_m1), .h_back_m1(hb_m1), .h_act_m1(ha_m1), .h_front_m1(hf_m1),
    .v_sync_m1(vs_m1), .v_back_m1(vb_m1), .v_act_m1(va_m1), .v_front_m1(vf_m1),
    .pol_hsync(p_hs), .pol_vsync(p_vs), .pol_de(p_de), .pol_data(p_dt),
    .pix_in(pix_in), .hsync(hsync), .vsync(vsync), .de(de), .pix_out(pix_out),
    .pix_x(pix_x), .pix_y(pix_y), .sof(sof), .vblank(vblank)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  // model state: settings of the frame in progress
  int c_hs, c_hb, c_ha, c_hf, c_vs, c_vb, c_va, c_vf;
  bit c_phs, c_pvs, c_pde, c_pdt;
  int mh, mv, tcyc, last_sof, exp_period;
  bit fresh;
  string ph;

  task automatic chk(bit ok, string rq, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s %s t=%0d actual=%0d expected=%0d", rq, ph, what, tcyc, act, exp);
    end
  endtask

  task automatic take_cfg();
    c_hs = int'(hs_m1) + 1; c_hb = int'(hb_m1) + 1;
    c_ha = int'(ha_m1) + 1; c_hf = int'(hf_m1) + 1;
    c_vs = int'(vs_m1) + 1; c_vb = int'(vb_m1) + 1;
    c_va = int'(va_m1) + 1; c_vf = int'(vf_m1) + 1;
    c_phs = p_hs; c_pvs = p_vs; c_pde = p_de; c_pdt = p_dt;
  endtask

  task automatic set_cfg(int a, int b, int c, int d, int e, int f, int g, int h,
                         bit q0, bit q1, bit q2, bit q3);
    hs_m1 = TW'(a - 1); hb_m1 = TW'(b - 1); ha_m1 = TW'(c - 1); hf_m1 = TW'(d - 1);
    vs_m1 = TW'(e - 1); vb_m1 = TW'(f - 1); va_m1 = TW'(g - 1); vf_m1 = TW'(h - 1);
    p_hs = q0; p_vs = q1; p_de = q2; p_dt = q3;
  endtask

  task automatic check_idle();
    chk(hsync == !p_hs, "R6", "hsync idle", hsync, !p_hs);
    chk(vsync == !p_vs, "R6", "vsync idle", vsync, !p_vs);
    chk(de == !p_de, "R6", "de idle", de, !p_de);
    chk(pix_x == 0 && pix_y == 0, "R6", "coords idle", pix_x + pix_y, 0);
    chk(!sof && !vblank, "R6", "pulses idle", sof + vblank, 0);
    chk(pix_out == 0, "R6", "pix idle", pix_out, 0);
  endtask

  task automatic check_run();
    int lin, hbase, vbase, ex, ey;
    bit hsa, vsa, ha, va, dea, esof, evb;
    logic [DW-1:0] ep;
    lin   = c_hs + c_hb + c_ha + c_hf;
    hbase = c_hs + c_hb;
    vbase = c_vs + c_vb;
    hsa = mh < c_hs;
    vsa = mv < c_vs;
    ha  = mh >= hbase && mh < hbase + c_ha;
    va  = mv >= vbase && mv < vbase + c_va;
    dea = ha && va;
    ex  = dea ? mh - hbase : 0;
    ey  = dea ? mv - vbase : 0;
    esof = mh == 0 && mv == 0;
    evb  = mv == vbase + c_va - 1 && mh == lin - 1;
    ep   = !dea ? '0 : (c_pdt ? pix_in : ~pix_in);
    chk(hsync == (c_phs ? hsa : !hsa), "R2", "hsync", hsync, c_phs ? hsa : !hsa);
    chk(vsync == (c_pvs ? vsa : !vsa), "R3", "vsync", vsync, c_pvs ? vsa : !vsa);
    chk(de == (c_pde ? dea : !dea), "R4", "de", de, c_pde ? dea : !dea);
    chk(int'(pix_x) == ex, "R4", "pix_x", pix_x, ex);
    chk(int'(pix_y) == ey, "R4", "pix_y", pix_y, ey);
    chk(pix_out == ep, "R5", "pix_out", pix_out, ep);
    chk(sof == esof, "R7", "sof", sof, esof);
    chk(vblank == evb, "R8", "vblank", vblank, evb);
    if (sof) begin
      if (last_sof >= 0) chk(tcyc - last_sof == exp_period, "R1", "frame period",
                             tcyc - last_sof, exp_period);
      last_sof   = tcyc;
      exp_period = lin * (c_vs + c_vb + c_va + c_vf);
    end
  endtask

  task automatic advance();
    int lin, frm;
    lin = c_hs + c_hb + c_ha + c_hf;
    frm = c_vs + c_vb + c_va + c_vf;
    if (mh == lin - 1) begin
      mh = 0;
      if (mv == frm - 1) begin
        mv = 0;
        take_cfg();
      end else mv++;
    end else mh++;
  endtask

  task automatic start_run();
    @(negedge clk);
    run_en = 1'b1;
    fresh = 1'b1;
    last_sof = -1;
  endtask

  task automatic run_cycles(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tcyc++;
      if (fresh) begin
        take_cfg();
        mh = 0; mv = 0;
        fresh = 1'b0;
      end else advance();
      pix_in = DW'(tcyc * 37 + 5);
      #2;
      check_run();
    end
  endtask

  task automatic stop_and_check();
    @(negedge clk);
    run_en = 1'b0;
    @(negedge clk);
    #2;
    check_idle();
  endtask

  initial begin
    ph = "reset";
    tcyc = 0;
    set_cfg(2, 3, 4, 2, 1, 2, 3, 1, 1, 1, 1, 1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #2;
    check_idle();

    // all polarities high, full sweep of two frames and part of a third
    ph = "pol_hi";
    start_run();
    run_cycles(2 * 77 + 20);
    stop_and_check();

    // change settings while stopped, then all polarities low
    set_cfg(2, 3, 4, 2, 1, 2, 3, 1, 0, 0, 0, 0);
    @(negedge clk);
    #2;
    check_idle();
    ph = "pol_lo";
    start_run();
    run_cycles(2 * 77 + 5);
    stop_and_check();

    // a different mode, mixed polarities
    set_cfg(1, 2, 5, 3, 2, 1, 2, 2, 1, 0, 1, 0);
    ph = "mixed";
    start_run();
    run_cycles(10);
    // R9: change in mid-frame, must wait for the next frame
    ph = "R9 midframe";
    set_cfg(3, 1, 3, 2, 1, 1, 4, 1, 0, 1, 0, 1);
    run_cycles(11 * 7 + 2 * 9 * 7 + 4);
    stop_and_check();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired at t=%0d", tcyc);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule